// File: doc/BRIEF.md
# Hierarchical Route Computation Unit

This unit sits in one input port of a 64-port folded-Clos router and turns a packet header into an output port one clock after the header is presented. It first decides whether the destination node lies in the subtree below this router. It does this by comparing the destination with a programmable subtree base, ignoring the bit positions selected by a programmable don't-care mask. Local destinations go down. A contiguous group of destination bits forms a logical downward port, and a remap table translates that logical port into the physical port that is actually wired.

Destinations outside the subtree go up. A small associative table keyed on the upper destination bits can steer such a packet to any chosen port, for example a specific uplink or a side link. When no entry matches, a deterministic spread is used. It is an XOR of the input port, the low destination bits and, optionally, low memory-address bits carried in the header. Repeated requests to one location therefore always leave on the same uplink. The unit also reports whether a later adaptive stage may override the up choice. That is allowed only for non-request packets that have the adaptive bit set. All tables are loaded through a single write port.

Top module: `hier_route_unit`

## Requirements
- R1: After reset, `rt_valid` is 0, the subtree base and mask are 0, every remap entry maps logical port i to physical port i, and every associative entry is invalid.
- R2: `rt_valid` is 1 exactly in the cycle after `hdr_valid` is 1. When no header was presented, `rt_port`, `rt_down` and `rt_adapt_ok` keep their previous values.
- R3: A destination is local, and `rt_down` is 1, when `(dest XOR base) AND NOT mask` is zero. For example, base 0x0060 with mask 0x001F makes nodes 96 to 127 local.
- R4: For a local destination, `rt_port` is the remap entry indexed by destination bits [4:0].
- R5: For a non-local destination with no associative match, `rt_port` is 32 plus the low 5 bits of `in_port XOR dest[5:0] XOR a`. Here `a` is `hdr_addr` when `hdr_use_addr` is 1, and 0 otherwise. `rt_down` is 0.
- R6: For a non-local destination, a valid associative entry whose tag equals destination bits [15:8] supplies `rt_port` directly. Of several matching entries, the one with the lowest index wins. The table is never consulted for local destinations.
- R7: `rt_adapt_ok` is 1 only for a non-local destination whose header has `hdr_adaptive` set and `hdr_is_req` clear.
- R8: Writes use `cfg_sel` to pick the target:
  - 0 writes the base from `cfg_data`.
  - 1 writes the mask from `cfg_data`.
  - 2 writes remap entry `cfg_idx[4:0]` from `cfg_data[5:0]`.
  - 3 writes associative entry `cfg_idx[1:0]`, with valid from bit 15, tag from bits [13:6] and port from bits [5:0].
- R9: A write takes effect for headers presented in later cycles. A header presented in the same cycle as a write is routed with the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Write target select |
| cfg_idx | input | 5 | Entry index for table writes |
| cfg_data | input | 16 | Write data |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_dest | input | 16 | Destination node number |
| hdr_in_port | input | 6 | Number of the arriving port |
| hdr_addr | input | 6 | Low memory-address bits for spreading |
| hdr_use_addr | input | 1 | Fold address bits into the up hash |
| hdr_is_req | input | 1 | Packet is a request |
| hdr_adaptive | input | 1 | Header asks for adaptive up routing |
| rt_valid | output | 1 | Route result valid |
| rt_port | output | 6 | Selected physical output port |
| rt_down | output | 1 | 1 for a downward route, 0 for upward |
| rt_adapt_ok | output | 1 | Adaptive override permitted |

## Verification
The hardest case to reach from the ports is a header that collides with a table write in the same cycle. The stimulus reaches it by raising `hdr_valid` and `cfg_we` on the same falling edge, with a write that changes the subtree base. It then checks that the result still follows the old base, and that a second header follows the new one. Priority between associative entries is exercised by loading two valid entries with the same tag. The reset defaults are observed before any write: an identity remap, and no associative hit even for destinations whose tag equals the cleared tag value.

// File: rtl/route_pkg.sv
package route_pkg;
  parameter int unsigned DEST_W    = 16;
  parameter int unsigned PORT_W    = 6;
  parameter int unsigned CFG_IDX_W = 5;

  typedef enum logic [1:0] {
    CFG_BASE  = 2'd0,
    CFG_MASK  = 2'd1,
    CFG_REMAP = 2'd2,
    CFG_ASSOC = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic              valid;
    logic              down;
    logic              adapt_ok;
    logic [PORT_W-1:0] port;
  } route_res_t;
endpackage

// File: rtl/route_cfg_regs.sv
module route_cfg_regs
  import route_pkg::*;
#(
  parameter int unsigned DN_LOG_W = 5,
  parameter int unsigned ASSOC_N  = 4,
  parameter int unsigned TAG_W    = 8,
  localparam int unsigned DN_N    = 1 << DN_LOG_W,
  localparam int unsigned AS_IW   = (ASSOC_N > 1) ? $clog2(ASSOC_N) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_sel,
  input  logic [CFG_IDX_W-1:0]      cfg_idx,
  input  logic [DEST_W-1:0]         cfg_data,
  output logic [DEST_W-1:0]         base_q,
  output logic [DEST_W-1:0]         mask_q,
  output logic [DN_N*PORT_W-1:0]    remap_q,
  output logic [ASSOC_N-1:0]        as_vld_q,
  output logic [ASSOC_N*TAG_W-1:0]  as_tag_q,
  output logic [ASSOC_N*PORT_W-1:0] as_port_q
);
  cfg_sel_e sel;
  assign sel = cfg_sel_e'(cfg_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
    end else if (cfg_we) begin
      if (sel == CFG_BASE) base_q <= cfg_data;
      if (sel == CFG_MASK) mask_q <= cfg_data;
    end
  end

  for (genvar i = 0; i < DN_N; i++) begin : g_remap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        remap_q[i*PORT_W +: PORT_W] <= PORT_W'(i);
      else if (cfg_we && sel == CFG_REMAP && cfg_idx[DN_LOG_W-1:0] == DN_LOG_W'(i))
        remap_q[i*PORT_W +: PORT_W] <= cfg_data[PORT_W-1:0];
    end
  end

  for (genvar j = 0; j < ASSOC_N; j++) begin : g_assoc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        as_vld_q[j]                    <= 1'b0;
        as_tag_q[j*TAG_W +: TAG_W]     <= '0;
        as_port_q[j*PORT_W +: PORT_W]  <= '0;
      end else if (cfg_we && sel == CFG_ASSOC && cfg_idx[AS_IW-1:0] == AS_IW'(j)) begin
        as_vld_q[j]                    <= cfg_data[DEST_W-1];
        as_tag_q[j*TAG_W +: TAG_W]     <= cfg_data[PORT_W +: TAG_W];
        as_port_q[j*PORT_W +: PORT_W]  <= cfg_data[PORT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/route_assoc_lookup.sv
module route_assoc_lookup
  import route_pkg::*;
#(
  parameter int unsigned ASSOC_N = 4,
  parameter int unsigned TAG_W   = 8
) (
  input  logic [TAG_W-1:0]          key,
  input  logic [ASSOC_N-1:0]        vld,
  input  logic [ASSOC_N*TAG_W-1:0]  tags,
  input  logic [ASSOC_N*PORT_W-1:0] ports,
  output logic                      hit,
  output logic [PORT_W-1:0]         port
);
  logic [ASSOC_N-1:0] match;

  for (genvar j = 0; j < ASSOC_N; j++) begin : g_cmp
    assign match[j] = vld[j] && (tags[j*TAG_W +: TAG_W] == key);
  end

  // lowest matching index wins: scan downward so it is written last
  always_comb begin
    port = '0;
    for (int k = ASSOC_N - 1; k >= 0; k--) begin
      if (match[k]) port = ports[k*PORT_W +: PORT_W];
    end
  end

  assign hit = |match;
endmodule

// File: rtl/hier_route_unit.sv
module hier_route_unit
  import route_pkg::*;
#(
  parameter int unsigned DN_LOG_W = 5,
  parameter int unsigned DN_SHIFT = 0,
  parameter int unsigned ASSOC_N  = 4,
  parameter int unsigned TAG_W    = 8,
  parameter int unsigned UP_BASE  = 32,
  localparam int unsigned DN_N    = 1 << DN_LOG_W,
  localparam int unsigned UP_W    = PORT_W - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [CFG_IDX_W-1:0] cfg_idx,
  input  logic [DEST_W-1:0]    cfg_data,
  input  logic                 hdr_valid,
  input  logic [DEST_W-1:0]    hdr_dest,
  input  logic [PORT_W-1:0]    hdr_in_port,
  input  logic [PORT_W-1:0]    hdr_addr,
  input  logic                 hdr_use_addr,
  input  logic                 hdr_is_req,
  input  logic                 hdr_adaptive,
  output logic                 rt_valid,
  output logic [PORT_W-1:0]    rt_port,
  output logic                 rt_down,
  output logic                 rt_adapt_ok
);
  function automatic logic in_subtree(input logic [DEST_W-1:0] d,
                                      input logic [DEST_W-1:0] b,
                                      input logic [DEST_W-1:0] m);
    return ((d ^ b) & ~m) == '0;
  endfunction

  function automatic logic [DN_LOG_W-1:0] down_logical(input logic [DEST_W-1:0] d);
    return DN_LOG_W'(d >> DN_SHIFT);
  endfunction

  function automatic logic [PORT_W-1:0] up_spread(input logic [PORT_W-1:0] ip,
                                                  input logic [DEST_W-1:0] d,
                                                  input logic              use_a,
                                                  input logic [PORT_W-1:0] a);
    logic [PORT_W-1:0] mix;
    mix = ip ^ d[PORT_W-1:0] ^ (use_a ? a : '0);
    return PORT_W'(UP_BASE) + PORT_W'(mix[UP_W-1:0]);
  endfunction

  logic [DEST_W-1:0]         base_q, mask_q;
  logic [DN_N*PORT_W-1:0]    remap_q;
  logic [ASSOC_N-1:0]        as_vld_q;
  logic [ASSOC_N*TAG_W-1:0]  as_tag_q;
  logic [ASSOC_N*PORT_W-1:0] as_port_q;

  route_cfg_regs #(.DN_LOG_W(DN_LOG_W), .ASSOC_N(ASSOC_N), .TAG_W(TAG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .base_q(base_q), .mask_q(mask_q),
    .remap_q(remap_q), .as_vld_q(as_vld_q), .as_tag_q(as_tag_q), .as_port_q(as_port_q)
  );

  // named decision wires, observed by the checker
  logic                local_hit;
  logic                assoc_hit;
  logic [PORT_W-1:0]   assoc_port;
  logic [DN_LOG_W-1:0] dn_logical;
  logic [PORT_W-1:0]   dn_port;
  logic [PORT_W-1:0]   hash_port;
  route_res_t          nxt, res_q;

  route_assoc_lookup #(.ASSOC_N(ASSOC_N), .TAG_W(TAG_W)) u_assoc (
    .key(hdr_dest[DEST_W-1 -: TAG_W]), .vld(as_vld_q), .tags(as_tag_q),
    .ports(as_port_q), .hit(assoc_hit), .port(assoc_port)
  );

  assign local_hit  = in_subtree(hdr_dest, base_q, mask_q);
  assign dn_logical = down_logical(hdr_dest);
  assign dn_port    = remap_q[dn_logical*PORT_W +: PORT_W];
  assign hash_port  = up_spread(hdr_in_port, hdr_dest, hdr_use_addr, hdr_addr);

  always_comb begin
    nxt.valid    = 1'b1;
    nxt.down     = local_hit;
    nxt.adapt_ok = !local_hit && hdr_adaptive && !hdr_is_req;
    if (local_hit)      nxt.port = dn_port;
    else if (assoc_hit) nxt.port = assoc_port;
    else                nxt.port = hash_port;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (hdr_valid) begin
      res_q <= nxt;
    end else begin
      res_q.valid <= 1'b0;
    end
  end

  assign rt_valid    = res_q.valid;
  assign rt_port     = res_q.port;
  assign rt_down     = res_q.down;
  assign rt_adapt_ok = res_q.adapt_ok;
endmodule

// File: rtl/route_chk.sv
module route_chk
  import route_pkg::*;
#(
  parameter int unsigned UP_BASE = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hdr_valid,
  input logic              hdr_is_req,
  input logic              local_hit,
  input logic              assoc_hit,
  input logic              rt_valid,
  input logic              rt_down,
  input logic              rt_adapt_ok,
  input logic [PORT_W-1:0] rt_port
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> rt_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> (!rt_valid && $stable(rt_port) && $stable(rt_down) && $stable(rt_adapt_ok)));

  // R3
  down_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && local_hit) |=> rt_down);

  // R5
  up_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !local_hit && !assoc_hit) |=> (!rt_down && rt_port >= PORT_W'(UP_BASE)));

  // R7
  req_no_adapt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_is_req) |=> !rt_adapt_ok);

  // R7
  down_no_adapt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_valid && rt_down) |-> !rt_adapt_ok);
endmodule

bind hier_route_unit route_chk #(.UP_BASE(UP_BASE)) u_route_chk (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_is_req(hdr_is_req),
  .local_hit(local_hit), .assoc_hit(assoc_hit), .rt_valid(rt_valid),
  .rt_down(rt_down), .rt_adapt_ok(rt_adapt_ok), .rt_port(rt_port)
);

// File: tb/hier_route_unit_bench.sv
module hier_route_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [4:0]  cfg_idx = '0;
  logic [15:0] cfg_data = '0;
  logic        hdr_valid = 1'b0;
  logic [15:0] hdr_dest = '0;
  logic [5:0]  hdr_in_port = '0;
  logic [5:0]  hdr_addr = '0;
  logic        hdr_use_addr = 1'b0;
  logic        hdr_is_req = 1'b0;
  logic        hdr_adaptive = 1'b0;
  logic        rt_valid, rt_down, rt_adapt_ok;
  logic [5:0]  rt_port;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hier_route_unit u_hier_route_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .hdr_valid(hdr_valid), .hdr_dest(hdr_dest),
    .hdr_in_port(hdr_in_port), .hdr_addr(hdr_addr), .hdr_use_addr(hdr_use_addr),
    .hdr_is_req(hdr_is_req), .hdr_adaptive(hdr_adaptive), .rt_valid(rt_valid),
    .rt_port(rt_port), .rt_down(rt_down), .rt_adapt_ok(rt_adapt_ok)
  );

  // bench-side mirror of what has been written
  logic [15:0] m_base = '0, m_mask = '0;
  logic [5:0]  m_remap [32];
  logic        m_av [4];
  logic [7:0]  m_at [4];
  logic [5:0]  m_ap [4];

  typedef struct packed {
    logic [15:0] dest;
    logic [5:0]  inp;
    logic        use_a;
    logic [5:0]  addr;
    logic        req;
    logic        adapt;
    logic        exp_down;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{16'h0060, 6'd3,  1'b0, 6'd0,  1'b0, 1'b0, 1'b1},
    '{16'h007F, 6'd9,  1'b0, 6'd0,  1'b1, 1'b0, 1'b1},
    '{16'h0080, 6'd2,  1'b0, 6'd0,  1'b1, 1'b0, 1'b0},
    '{16'h005F, 6'd33, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0},
    '{16'h1234, 6'd4,  1'b0, 6'd0,  1'b0, 1'b0, 1'b0},
    '{16'hA005, 6'd1,  1'b0, 6'd0,  1'b1, 1'b0, 1'b0},
    '{16'h0301, 6'd7,  1'b1, 6'h15, 1'b1, 1'b0, 1'b0},
    '{16'h0301, 6'd7,  1'b0, 6'h15, 1'b1, 1'b0, 1'b0},
    '{16'h4444, 6'd60, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0},
    '{16'h4444, 6'd60, 1'b0, 6'd0,  1'b1, 1'b1, 1'b0}
  };

  function automatic logic [5:0] model_port(input logic [15:0] d, input logic [5:0] ip,
                                            input logic ua, input logic [5:0] a);
    int v;
    if (((d ^ m_base) & ~m_mask) == 16'h0) return m_remap[d % 32];
    for (int i = 0; i < 4; i++) if (m_av[i] && m_at[i] == d[15:8]) return m_ap[i];
    v = (ip ^ d[5:0] ^ (ua ? a : 6'd0)) % 32;
    return 6'(32 + v);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [4:0] idx, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_idx = idx; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (s)
      2'd0: m_base = d;
      2'd1: m_mask = d;
      2'd2: m_remap[idx] = d[5:0];
      default: begin m_av[idx[1:0]] = d[15]; m_at[idx[1:0]] = d[13:6]; m_ap[idx[1:0]] = d[5:0]; end
    endcase
  endtask

  // presents a header for one cycle; result is read at the following falling edge
  task automatic send(input logic [15:0] d, input logic [5:0] ip, input logic ua,
                      input logic [5:0] a, input logic rq, input logic ad);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_dest = d; hdr_in_port = ip; hdr_use_addr = ua;
    hdr_addr = a; hdr_is_req = rq; hdr_adaptive = ad;
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_remap[i] = 6'(i);
    for (int i = 0; i < 4; i++) begin m_av[i] = 1'b0; m_at[i] = '0; m_ap[i] = '0; end
    repeat (3) @(negedge clk);
    check("R1", "rt_valid in reset", int'(rt_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "rt_valid after reset", int'(rt_valid), 0);

    // R1 defaults: identity remap, node 0 local, tag 0 not matched
    send(16'h0000, 6'd5, 1'b0, 6'd0, 1'b0, 1'b0);
    check("R1", "default down", int'(rt_down), 1);
    check("R1", "identity remap", int'(rt_port), 0);
    send(16'h0005, 6'd12, 1'b0, 6'd0, 1'b0, 1'b0);
    check("R1", "no assoc hit on cleared tag", int'(rt_port), int'(model_port(16'h0005, 6'd12, 1'b0, 6'd0)));
    check("R2", "valid one cycle after header", int'(rt_valid), 1);

    // program tables (R8)
    cfg_write(2'd0, 5'd0, 16'h0060);
    cfg_write(2'd1, 5'd0, 16'h001F);
    cfg_write(2'd2, 5'd0, 16'd17);
    cfg_write(2'd2, 5'd31, 16'd50);
    cfg_write(2'd3, 5'd0, {1'b1, 1'b0, 8'hA0, 6'd5});
    cfg_write(2'd3, 5'd1, {1'b1, 1'b0, 8'h12, 6'd40});
    cfg_write(2'd3, 5'd2, {1'b1, 1'b0, 8'h12, 6'd7});

    for (int v = 0; v < NV; v++) begin
      send(VECS[v].dest, VECS[v].inp, VECS[v].use_a, VECS[v].addr, VECS[v].req, VECS[v].adapt);
      check("R2", "valid", int'(rt_valid), 1);
      check("R3", "down flag", int'(rt_down), int'(VECS[v].exp_down));
      check(VECS[v].exp_down ? "R4" : "R5/R6", "port", int'(rt_port),
            int'(model_port(VECS[v].dest, VECS[v].inp, VECS[v].use_a, VECS[v].addr)));
      check("R7", "adapt_ok", int'(rt_adapt_ok),
            int'(!VECS[v].exp_down && VECS[v].adapt && !VECS[v].req));
    end

    // R6 priority and side-link target explicitly
    send(16'h12FF, 6'd0, 1'b0, 6'd0, 1'b0, 1'b0);
    check("R6", "lowest index wins", int'(rt_port), 40);
    send(16'hA0FF, 6'd0, 1'b0, 6'd0, 1'b0, 1'b0);
    check("R6", "side link entry", int'(rt_port), 5);
    // R6: local destination ignores table even if tag would match (base 0x1260 region)
    cfg_write(2'd0, 5'd0, 16'h1260);
    send(16'h1265, 6'd0, 1'b0, 6'd0, 1'b0, 1'b0);
    check("R6", "local skips table down", int'(rt_down), 1);
    check("R6", "local skips table port", int'(rt_port), 5);

    // R2 hold: idle cycle keeps port and flags
    @(negedge clk);
    check("R2", "idle valid low", int'(rt_valid), 0);
    check("R2", "idle port held", int'(rt_port), 5);

    // R9: write and header in the same cycle -> old base 0x1260 used
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_idx = '0; cfg_data = 16'h0060;
    hdr_valid = 1'b1; hdr_dest = 16'h0061; hdr_in_port = 6'd2; hdr_use_addr = 1'b0;
    hdr_is_req = 1'b0; hdr_adaptive = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; hdr_valid = 1'b0;
    check("R9", "same-cycle write uses old base", int'(rt_down), 0);
    check("R9", "same-cycle port", int'(rt_port), int'(model_port(16'h0061, 6'd2, 1'b0, 6'd0)));
    m_base = 16'h0060;
    send(16'h0061, 6'd2, 1'b0, 6'd0, 1'b0, 1'b0);
    check("R9", "next header uses new base", int'(rt_down), 1);
    check("R8", "remap identity entry 1", int'(rt_port), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule